// File: doc/BRIEF.md
# I2C Multi-Master Bus State Monitor

This block sits beside a local I2C master and follows the two bus lines to decide whether that master may start a transfer. It keeps a four-valued ownership state. The state is unknown while the block is disabled or has just been enabled. It is idle when the bus is free, owned once the local master has been granted a start, and busy when another master holds the bus.

The block synchronizes the raw clock and data levels and finds start and stop conditions on them. In the unknown state it runs a quiet-time counter against a programmable limit. While it owns the bus it compares the level the local master drives on the data line with the level it sees there. If the master releases the line but another master pulls it low, the block flags lost arbitration and hands the bus to the other side.

A start request is granted only from the idle state. A request at any other time is refused with a one-cycle pulse.

Top module: `i2c_bus_monitor`

## Requirements
- R1: In reset, and on the clock edge after enable is low, busState reads UNKNOWN (2'b00). The state encodings are UNKNOWN=00, IDLE=01, OWNER=10 and BUSY=11. The detect pulses, arbLost and busyReject are low after reset.
- R2: The quiet-time counter runs only while the block is enabled and in UNKNOWN, and it restarts on any edge of either synchronized line. With both lines quiet, the state becomes IDLE on the (timeoutLimit+1)th clock edge after enable rises.
- R3: From UNKNOWN, the state can only go to IDLE. A stop condition moves it there at once, and a start condition alone leaves it in UNKNOWN.
- R4: startDet pulses for one cycle when synchronized SDA falls while SCL is high, and stopDet pulses for one cycle when SDA rises while SCL is high. Each pulse appears two clock edges after the line change and never together with the other.
- R5: A startReq in IDLE, with no start condition detected in the same cycle, makes the state OWNER on the next edge.
- R6: A start condition detected in IDLE makes the state BUSY.
- R7: A start condition seen in OWNER or BUSY (the local master's own start, or a repeated start) leaves the state unchanged.
- R8: A stop condition in OWNER or BUSY returns the state to IDLE.
- R9: In OWNER, if SCL is high on two consecutive synchronized samples while the local master releases SDA (sdaDrive=1) and SDA reads low, the state becomes BUSY and arbLost rises on the same edge.
- R10: arbLost stays high until a cycle with arbClear or startReq high. That cycle clears it on the next edge.
- R11: A startReq made when the state is not IDLE, or while disabled, does not change the state. It raises busyReject for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low forces UNKNOWN |
| sclIn | input | 1 | Raw SCL level seen on the bus |
| sdaIn | input | 1 | Raw SDA level seen on the bus |
| sdaDrive | input | 1 | SDA level the local master drives (1 = released) |
| startReq | input | 1 | Local master asks to issue a start |
| arbClear | input | 1 | Clears the arbitration-lost flag |
| timeoutLimit | input | TO_W | Quiet-cycle limit for leaving UNKNOWN |
| busState | output | 2 | Ownership state (see R1 for encoding) |
| startDet | output | 1 | One-cycle start condition pulse |
| stopDet | output | 1 | One-cycle stop condition pulse |
| arbLost | output | 1 | Sticky arbitration-lost flag |
| busyReject | output | 1 | One-cycle pulse for a refused start request |

## Verification
The hardest case to reach is lost arbitration. It needs the block in OWNER, a local start already on the bus, and then an SCL high phase in which the local master releases SDA while a second master holds it low. The bench models the wired-AND bus as the AND of two drivers, one local and one foreign. Each driver moves only while SCL is low. The clock is then raised and the bench waits out the three register stages before it samples. The restart of the quiet-time counter is the other subtle case. It is reached by pulsing SCL partway through the unknown window and checking that the state is still UNKNOWN past the point where an unbroken count would have expired.

// File: rtl/busmon_pkg.sv
package busmon_pkg;

  typedef enum logic [1:0] {
    ST_UNKNOWN = 2'b00,
    ST_IDLE    = 2'b01,
    ST_OWNER   = 2'b10,
    ST_BUSY    = 2'b11
  } busState_e;

  // line events reported by the datapath to the control
  typedef struct packed {
    logic startSeen;
    logic stopSeen;
    logic arbMismatch;
    logic quietExpired;
  } lineEvents_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic countEn;
  } ctrlStrobes_t;

endpackage

// File: rtl/busmon_sync.sv
module busmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= 1'b1;
        else       pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/busmon_datapath.sv
module busmon_datapath
  import busmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TO_W        = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  input  logic            sdaDrive,
  input  logic [TO_W-1:0] timeoutLimit,
  input  ctrlStrobes_t    strobes,
  output lineEvents_t     events
);
  logic sclS, sdaS, driveS;
  logic sclPrev, sdaPrev;
  logic anyEdge;
  logic [TO_W-1:0] quietCnt;

  busmon_sync #(.STAGES(SYNC_STAGES)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  busmon_sync #(.STAGES(SYNC_STAGES)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));
  // local drive level delayed the same way so it lines up with the bus sample
  busmon_sync #(.STAGES(SYNC_STAGES)) u_drvSync (
    .clk(clk), .rstN(rstN), .din(sdaDrive), .dout(driveS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign anyEdge = (sclS ^ sclPrev) | (sdaS ^ sdaPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           quietCnt <= '0;
    else if (!strobes.countEn || anyEdge) quietCnt <= '0;
    else if (quietCnt != timeoutLimit)   quietCnt <= quietCnt + 1'b1;
  end

  always_comb begin
    events.startSeen    = sclPrev & sclS & sdaPrev & ~sdaS;
    events.stopSeen     = sclPrev & sclS & ~sdaPrev & sdaS;
    events.arbMismatch  = sclPrev & sclS & driveS & ~sdaS;
    events.quietExpired = strobes.countEn & ~anyEdge & (quietCnt == timeoutLimit);
  end
endmodule

// File: rtl/busmon_control.sv
module busmon_control
  import busmon_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         startReq,
  input  logic         arbClear,
  input  lineEvents_t  events,
  output busState_e    state,
  output ctrlStrobes_t strobes,
  output logic         arbLost,
  output logic         busyReject
);
  busState_e nextState;
  logic      rejectNow;
  logic      setLost;

  always_comb begin
    nextState = state;
    rejectNow = 1'b0;
    setLost   = 1'b0;
    if (!enable) begin
      nextState = ST_UNKNOWN;
      rejectNow = startReq;
    end else begin
      case (state)
        ST_UNKNOWN: begin
          rejectNow = startReq;
          if (events.stopSeen || events.quietExpired) nextState = ST_IDLE;
        end
        ST_IDLE: begin
          if (events.startSeen) begin
            nextState = ST_BUSY;
            rejectNow = startReq;
          end else if (startReq) begin
            nextState = ST_OWNER;
          end
        end
        ST_OWNER: begin
          rejectNow = startReq;
          if (events.stopSeen) begin
            nextState = ST_IDLE;
          end else if (events.arbMismatch) begin
            nextState = ST_BUSY;
            setLost   = 1'b1;
          end
        end
        default: begin
          rejectNow = startReq;
          if (events.stopSeen) nextState = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_UNKNOWN;
      busyReject <= 1'b0;
      arbLost    <= 1'b0;
    end else begin
      state      <= nextState;
      busyReject <= rejectNow;
      if (setLost)                   arbLost <= 1'b1;
      else if (arbClear || startReq) arbLost <= 1'b0;
    end
  end

  assign strobes.countEn = enable && (state == ST_UNKNOWN);
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import busmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TO_W        = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            sclIn,
  input  logic            sdaIn,
  input  logic            sdaDrive,
  input  logic            startReq,
  input  logic            arbClear,
  input  logic [TO_W-1:0] timeoutLimit,
  output logic [1:0]      busState,
  output logic            startDet,
  output logic            stopDet,
  output logic            arbLost,
  output logic            busyReject
);
  lineEvents_t  events;
  ctrlStrobes_t strobes;
  busState_e    state;

  busmon_datapath #(.SYNC_STAGES(SYNC_STAGES), .TO_W(TO_W)) u_datapath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaDrive(sdaDrive),
    .timeoutLimit(timeoutLimit), .strobes(strobes), .events(events));

  busmon_control u_control (
    .clk(clk), .rstN(rstN), .enable(enable), .startReq(startReq),
    .arbClear(arbClear), .events(events), .state(state), .strobes(strobes),
    .arbLost(arbLost), .busyReject(busyReject));

  assign busState = state;
  assign startDet = events.startSeen;
  assign stopDet  = events.stopSeen;
endmodule

// File: rtl/busmon_checker.sv
module busmon_checker (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       startReq,
  input logic       arbClear,
  input logic [1:0] busState,
  input logic       startDet,
  input logic       stopDet,
  input logic       arbLost,
  input logic       busyReject
);
  // R1
  disabled_unknown_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> busState == 2'b00);

  // R3
  unknown_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    busState == 2'b00 |=> (busState == 2'b00 || busState == 2'b01));

  // R4
  det_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(startDet && stopDet));

  // R5
  grant_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && busState == 2'b01 && startReq && !startDet) |=> busState == 2'b10);

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && stopDet && busState[1]) |=> busState == 2'b01);

  // R9
  lost_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbLost) |-> busState == 2'b11);

  // R10
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arbLost && !arbClear && !startReq) |=> arbLost);

  // R11
  reject_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && busState != 2'b01 && startReq) |=> busyReject);

  // R11
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyReject |-> $past(startReq));
endmodule

bind i2c_bus_monitor busmon_checker u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .startReq(startReq),
  .arbClear(arbClear), .busState(busState), .startDet(startDet),
  .stopDet(stopDet), .arbLost(arbLost), .busyReject(busyReject));

// File: tb/i2c_bus_monitor_tb.sv
module i2c_bus_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TO_W = 16;

  localparam logic [1:0] S_UNK = 2'b00, S_IDLE = 2'b01, S_OWN = 2'b10, S_BUSY = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic sclBus = 1'b1;
  logic localDrv = 1'b1;
  logic otherDrv = 1'b1;
  logic startReq = 1'b0;
  logic arbClear = 1'b0;
  logic [TO_W-1:0] timeoutLimit = 16'd20;
  logic [1:0] busState;
  logic startDet, stopDet, arbLost, busyReject;
  logic sdaBus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign sdaBus = localDrv & otherDrv;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bus_monitor #(.TO_W(TO_W)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .sclIn(sclBus), .sdaIn(sdaBus),
    .sdaDrive(localDrv), .startReq(startReq), .arbClear(arbClear),
    .timeoutLimit(timeoutLimit), .busState(busState), .startDet(startDet),
    .stopDet(stopDet), .arbLost(arbLost), .busyReject(busyReject));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulseReq();
    startReq = 1'b1;
    tick(1);
    startReq = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 reset state", busState, S_UNK);
    chk("R1 reset startDet", startDet, 0);
    chk("R1 reset arbLost", arbLost, 0);
    chk("R1 reset busyReject", busyReject, 0);
  endtask

  task automatic testTimeout();
    enable = 1'b1;
    tick(20);
    chk("R2 before expiry", busState, S_UNK);
    tick(1);
    chk("R2 expiry to IDLE", busState, S_IDLE);
    // restart on a line edge
    enable = 1'b0; tick(1);
    chk("R1 disabled", busState, S_UNK);
    enable = 1'b1; tick(10);
    sclBus = 1'b0; tick(1);
    sclBus = 1'b1; tick(10);
    chk("R2 counter restarted", busState, S_UNK);
    tick(30);
    chk("R2 late expiry", busState, S_IDLE);
  endtask

  task automatic testStopFromUnknown();
    enable = 1'b0; tick(1);
    timeoutLimit = 16'd1000;
    enable = 1'b1; tick(2);
    otherDrv = 1'b0; tick(2);
    chk("R4 startDet pulse", startDet, 1);
    chk("R3 start keeps UNKNOWN", busState, S_UNK);
    otherDrv = 1'b1; tick(2);
    chk("R4 stopDet pulse", stopDet, 1);
    chk("R4 no start with stop", startDet, 0);
    tick(1);
    chk("R3 stop to IDLE", busState, S_IDLE);
    chk("R4 stopDet one cycle", stopDet, 0);
  endtask

  task automatic testOwnTransfer();
    pulseReq();
    chk("R5 grant OWNER", busState, S_OWN);
    localDrv = 1'b0; tick(2);
    chk("R4 own start seen", startDet, 1);
    tick(1);
    chk("R7 own start keeps OWNER", busState, S_OWN);
    sclBus = 1'b0; tick(3);
    localDrv = 1'b1; tick(3);
    sclBus = 1'b1; tick(4);
    chk("R9 no mismatch when bus agrees", arbLost, 0);
    chk("R9 still OWNER", busState, S_OWN);
    sclBus = 1'b0; tick(3);
    localDrv = 1'b0; tick(3);
    sclBus = 1'b1; tick(3);
    localDrv = 1'b1; tick(2);
    chk("R4 own stop seen", stopDet, 1);
    tick(1);
    chk("R8 OWNER stop to IDLE", busState, S_IDLE);
  endtask

  task automatic foreignStop();
    sclBus = 1'b0; tick(3);
    otherDrv = 1'b0; tick(3);
    sclBus = 1'b1; tick(3);
    otherDrv = 1'b1; tick(3);
  endtask

  task automatic testForeign();
    otherDrv = 1'b0; tick(2);
    chk("R4 foreign start", startDet, 1);
    tick(1);
    chk("R6 foreign start BUSY", busState, S_BUSY);
    startReq = 1'b1; tick(1);
    startReq = 1'b0;
    chk("R11 reject pulse", busyReject, 1);
    chk("R11 state unchanged", busState, S_BUSY);
    tick(1);
    chk("R11 reject one cycle", busyReject, 0);
    sclBus = 1'b0; tick(3);
    otherDrv = 1'b1; tick(3);
    sclBus = 1'b1; tick(3);
    otherDrv = 1'b0; tick(2);
    chk("R4 repeated start", startDet, 1);
    tick(1);
    chk("R7 repeated start keeps BUSY", busState, S_BUSY);
    foreignStop();
    chk("R8 BUSY stop to IDLE", busState, S_IDLE);
  endtask

  task automatic loseArb();
    pulseReq();
    chk("R5 grant before contest", busState, S_OWN);
    localDrv = 1'b0; otherDrv = 1'b0; tick(3);
    sclBus = 1'b0; tick(3);
    localDrv = 1'b1; tick(3);
    sclBus = 1'b1; tick(3);
    chk("R9 not yet lost", arbLost, 0);
    tick(1);
    chk("R9 arbLost set", arbLost, 1);
    chk("R9 state BUSY", busState, S_BUSY);
  endtask

  task automatic testArbByRequest();
    loseArb();
    tick(5);
    chk("R10 sticky", arbLost, 1);
    startReq = 1'b1; tick(1);
    startReq = 1'b0;
    chk("R10 request clears", arbLost, 0);
    chk("R11 request rejected in BUSY", busyReject, 1);
    sclBus = 1'b0; tick(3);
    sclBus = 1'b1; tick(3);
    otherDrv = 1'b1; tick(3);
    chk("R8 back to IDLE", busState, S_IDLE);
  endtask

  task automatic testArbByClear();
    loseArb();
    arbClear = 1'b1; tick(1);
    arbClear = 1'b0;
    chk("R10 clear input", arbLost, 0);
    chk("R10 clear keeps BUSY", busState, S_BUSY);
    sclBus = 1'b0; tick(3);
    sclBus = 1'b1; tick(3);
    otherDrv = 1'b1; tick(3);
    chk("R8 IDLE after clear", busState, S_IDLE);
  endtask

  task automatic testDisable();
    pulseReq();
    chk("R5 grant again", busState, S_OWN);
    enable = 1'b0; tick(1);
    chk("R1 disable forces UNKNOWN", busState, S_UNK);
    startReq = 1'b1; tick(1);
    startReq = 1'b0;
    chk("R11 reject while disabled", busyReject, 1);
    chk("R11 disabled stays UNKNOWN", busState, S_UNK);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    tick(3);
    testReset();
    rstN = 1'b1;
    tick(2);
    testReset();
    testTimeout();
    testStopFromUnknown();
    testOwnTransfer();
    testForeign();
    testArbByRequest();
    testArbByClear();
    testDisable();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end
endmodule